// File: doc/BRIEF.md
# Table-Driven PID Duty Compensator

This block closes the voltage loop of a switched-mode converter. It runs once per switching period. Each period a windowed flash quantizer delivers a 4-bit error code, and the block returns a new 13-bit duty cycle for the modulator that follows it. The block does not multiply. Each of the three PID terms is a product of a coefficient and a quantized error. Because the error takes only thirteen values, each product is read from a small signed table. Each table is indexed by the error code of one sample age: the current sample, one sample back, or two samples back. The three table outputs are added to the previous duty value.

The running duty value is held in a 24-bit accumulator. Its low 11 bits are fraction bits, so small coefficients still take effect over many periods. The accumulator saturates rather than wrapping. The duty output is the top 13 bits of the accumulator.

Before the loop runs, software loads the tables through a simple write port. After reset every table entry is zero, so the loop has no gain. The quantizer can produce codes 13 to 15, which are illegal. The block handles any such code as the largest legal code, 12, and sets a flag that stays set until reset.

Top module: `pid_duty_comp`

## Requirements
- R1: After reset, duty is 0, dutyValid is 0, codeErr is 0 and every table entry is 0. As a result, samples taken before any table write leave duty at 0.
- R2: dutyValid is high for exactly the one cycle that follows a clock edge at which sampleStb was high. It is low at all other times.
- R3: On each sample, the accumulator becomes prevAcc + A[e0] + B[e1] + C[e2]. The accumulator is 24 bits unsigned with 11 fraction bits. Table entries are 24-bit two's complement. duty is accumulator bits [23:11].
- R4: e0 is the code presented with the current strobe, e1 is the code of the previous sample and e2 is the code of the sample before that. The history registers shift only on a strobe. After reset both history registers hold code 6, which stands for zero error.
- R5: The accumulator saturates at 0 and at 2^24-1. At those limits duty is 0 and 8191.
- R6: Codes 13, 14 and 15 are used as code 12, both for the current lookup and in the stored history.
- R7: A strobe that carries a code above 12 sets codeErr. codeErr stays set until reset.
- R8: A table write takes place when tblWe is high at a clock edge and sampleStb is low. tblSel 0, 1 and 2 select tables A, B and C, and tblAddr selects an entry from 0 to 12. The write is dropped if sampleStb is high, if tblSel is 3, or if tblAddr is above 12.
- R9: duty holds its value in every cycle that does not follow a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStb | input | 1 | One-cycle strobe, once per switching period |
| errCode | input | 4 | Quantized error code; 0 to 12 stand for errors -6 to +6 |
| tblWe | input | 1 | Table write enable |
| tblSel | input | 2 | Table select: 0 = A, 1 = B, 2 = C |
| tblAddr | input | 4 | Table entry index |
| tblData | input | 24 | Signed coefficient product to store |
| duty | output | 13 | Integer part of the duty accumulator |
| dutyValid | output | 1 | High the cycle a new duty value appears |
| codeErr | output | 1 | Sticky flag for illegal error codes |

## Verification
The checker assumes that the accepted code on each strobe is errCode clamped to 12, and that the history registers move only on a strobe. It also assumes that sampleStb is a clean synchronous signal, driven low throughout reset. The bench drives every input half a clock period away from the active edge. It keeps sampleStb low during reset. It sends illegal codes and collided writes only in dedicated phases, so that their effect on duty and codeErr can be predicted from the requirements. Sweeps step through all thirteen legal codes at every history age, with signed gains loaded into the tables.

// File: rtl/pid_comp_pkg.sv
package pid_comp_pkg;
  localparam int NUM_TBL = 3;

  typedef struct packed {
    logic sample;
    logic write;
  } ctrl_strb_t;
endpackage

// File: rtl/pid_comp_ctrl.sv
module pid_comp_ctrl
  import pid_comp_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int NUM_CODES = 13,
  parameter int SEL_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStb,
  input  logic [CODE_W-1:0] errCode,
  input  logic              tblWe,
  input  logic [SEL_W-1:0]  tblSel,
  input  logic [CODE_W-1:0] tblAddr,
  output ctrl_strb_t        strb,
  output logic [CODE_W-1:0] codeSafe,
  output logic              dutyValid,
  output logic              codeErr
);
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(NUM_CODES - 1);
  localparam logic [SEL_W-1:0]  LAST_SEL = SEL_W'(NUM_TBL - 1);

  logic codeIllegal;

  assign codeIllegal = errCode > MAX_CODE;
  assign codeSafe    = codeIllegal ? MAX_CODE : errCode;

  always_comb begin
    strb.sample = sampleStb;
    strb.write  = tblWe && !sampleStb && (tblAddr <= MAX_CODE) && (tblSel <= LAST_SEL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyValid <= 1'b0;
      codeErr   <= 1'b0;
    end else begin
      dutyValid <= sampleStb;
      if (sampleStb && codeIllegal) codeErr <= 1'b1;
    end
  end
endmodule

// File: rtl/pid_comp_datapath.sv
module pid_comp_datapath
  import pid_comp_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int NUM_CODES = 13,
  parameter int COEF_W    = 24,
  parameter int DUTY_W    = 13,
  parameter int SEL_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strb_t        strb,
  input  logic [CODE_W-1:0] codeSafe,
  input  logic [SEL_W-1:0]  tblSel,
  input  logic [CODE_W-1:0] tblAddr,
  input  logic [COEF_W-1:0] tblData,
  output logic [DUTY_W-1:0] duty,
  output logic [CODE_W-1:0] hist1,
  output logic [CODE_W-1:0] hist2
);
  localparam int ACC_W = COEF_W;
  localparam int SUM_W = ACC_W + 3;
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'((NUM_CODES - 1) / 2);

  logic [ACC_W-1:0]         acc;
  logic [CODE_W-1:0]        idx   [NUM_TBL];
  logic signed [COEF_W-1:0] rdVal [NUM_TBL];
  logic signed [SUM_W-1:0]  sum;
  logic [ACC_W-1:0]         accNext;

  always_comb begin
    idx[0] = codeSafe;
    idx[1] = hist1;
    idx[2] = hist2;
  end

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    logic signed [COEF_W-1:0] mem [NUM_CODES];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < NUM_CODES; i++) mem[i] <= '0;
      end else if (strb.write && tblSel == SEL_W'(t)) begin
        mem[tblAddr] <= tblData;
      end
    end

    assign rdVal[t] = mem[idx[t]];
  end

  always_comb begin
    sum = $signed({3'b000, acc});
    for (int t = 0; t < NUM_TBL; t++) sum = sum + SUM_W'(rdVal[t]);
    if (sum[SUM_W-1])                 accNext = '0;
    else if (|sum[SUM_W-2:ACC_W])     accNext = '1;
    else                              accNext = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc   <= '0;
      hist1 <= MID_CODE;
      hist2 <= MID_CODE;
    end else if (strb.sample) begin
      acc   <= accNext;
      hist1 <= codeSafe;
      hist2 <= hist1;
    end
  end

  assign duty = acc[ACC_W-1 -: DUTY_W];
endmodule

// File: rtl/pid_duty_comp.sv
module pid_duty_comp
  import pid_comp_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int NUM_CODES = 13,
  parameter int COEF_W    = 24,
  parameter int DUTY_W    = 13,
  parameter int SEL_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStb,
  input  logic [CODE_W-1:0] errCode,
  input  logic              tblWe,
  input  logic [SEL_W-1:0]  tblSel,
  input  logic [CODE_W-1:0] tblAddr,
  input  logic [COEF_W-1:0] tblData,
  output logic [DUTY_W-1:0] duty,
  output logic              dutyValid,
  output logic              codeErr
);
  ctrl_strb_t        strb;
  logic [CODE_W-1:0] codeSafe;
  logic [CODE_W-1:0] hist1;
  logic [CODE_W-1:0] hist2;

  pid_comp_ctrl #(
    .CODE_W(CODE_W), .NUM_CODES(NUM_CODES), .SEL_W(SEL_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .errCode(errCode),
    .tblWe(tblWe), .tblSel(tblSel), .tblAddr(tblAddr),
    .strb(strb), .codeSafe(codeSafe), .dutyValid(dutyValid), .codeErr(codeErr)
  );

  pid_comp_datapath #(
    .CODE_W(CODE_W), .NUM_CODES(NUM_CODES), .COEF_W(COEF_W),
    .DUTY_W(DUTY_W), .SEL_W(SEL_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .codeSafe(codeSafe),
    .tblSel(tblSel), .tblAddr(tblAddr), .tblData(tblData),
    .duty(duty), .hist1(hist1), .hist2(hist2)
  );
endmodule

// File: rtl/pid_duty_comp_chk.sv
module pid_duty_comp_chk #(
  parameter int CODE_W    = 4,
  parameter int NUM_CODES = 13,
  parameter int DUTY_W    = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleStb,
  input logic [CODE_W-1:0] errCode,
  input logic [DUTY_W-1:0] duty,
  input logic              dutyValid,
  input logic              codeErr,
  input logic [CODE_W-1:0] hist1,
  input logic [CODE_W-1:0] hist2
);
  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(NUM_CODES - 1);

  assert_valid_after_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> dutyValid);

  assert_valid_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    dutyValid |-> $past(sampleStb));

  assert_duty_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sampleStb) |-> $stable(duty));

  assert_hist_age_R4: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> hist2 == $past(hist1));

  assert_hist_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> $stable(hist1) && $stable(hist2));

  assert_hist_legal_R6: assert property (@(posedge clk) disable iff (!rstN)
    hist1 <= TOP_CODE && hist2 <= TOP_CODE);

  assert_illegal_clamped_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && errCode > TOP_CODE) |=> hist1 == TOP_CODE);

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && errCode > TOP_CODE) |=> codeErr);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    codeErr |=> codeErr);
endmodule

bind pid_duty_comp pid_duty_comp_chk #(
  .CODE_W(CODE_W), .NUM_CODES(NUM_CODES), .DUTY_W(DUTY_W)
) chk_i (
  .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .errCode(errCode),
  .duty(duty), .dutyValid(dutyValid), .codeErr(codeErr),
  .hist1(hist1), .hist2(hist2)
);

// File: tb/pid_duty_comp_tb_top.sv
module pid_duty_comp_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleStb = 1'b0;
  logic [3:0]  errCode = 4'd6;
  logic        tblWe = 1'b0;
  logic [1:0]  tblSel = 2'd0;
  logic [3:0]  tblAddr = 4'd0;
  logic [23:0] tblData = 24'd0;
  logic [12:0] duty;
  logic        dutyValid;
  logic        codeErr;

  int     nChecks = 0;
  int     nFails = 0;
  bit     finished = 1'b0;
  longint mA [13];
  longint mB [13];
  longint mC [13];
  longint mAcc = 0;
  int     mH1 = 6;
  int     mH2 = 6;
  longint prevDuty;

  localparam longint ACC_MAX = 64'd16777215;

  pid_duty_comp dut_i (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .errCode(errCode),
    .tblWe(tblWe), .tblSel(tblSel), .tblAddr(tblAddr), .tblData(tblData),
    .duty(duty), .dutyValid(dutyValid), .codeErr(codeErr)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sx24(input longint v);
    longint w = v & 64'hFFFFFF;
    return (w >= 64'h800000) ? w - 64'h1000000 : w;
  endfunction

  task automatic modelSample(input int code);
    int c = (code > 12) ? 12 : code;
    mAcc = mAcc + mA[c] + mB[mH1] + mC[mH2];
    if (mAcc < 0) mAcc = 0;
    if (mAcc > ACC_MAX) mAcc = ACC_MAX;
    mH2 = mH1;
    mH1 = c;
  endtask

  task automatic writeTbl(input int sel, input int addr, input longint val);
    @(negedge clk);
    tblWe = 1'b1; tblSel = 2'(sel); tblAddr = 4'(addr); tblData = val[23:0];
    @(negedge clk);
    tblWe = 1'b0;
    if (sel <= 2 && addr <= 12) begin
      if (sel == 0) mA[addr] = sx24(val);
      else if (sel == 1) mB[addr] = sx24(val);
      else mC[addr] = sx24(val);
    end
  endtask

  // One strobe, optionally with a colliding write; checks R2, R3, R9.
  task automatic doSample(input int code, input bit withWr, input string req);
    @(negedge clk);
    prevDuty = duty;
    sampleStb = 1'b1; errCode = 4'(code);
    if (withWr) begin
      tblWe = 1'b1; tblSel = 2'd0; tblAddr = 4'(code > 12 ? 12 : code);
      tblData = 24'h3FFFFF;
    end
    @(negedge clk);
    sampleStb = 1'b0; tblWe = 1'b0;
    modelSample(code);
    chk(req, longint'(duty), mAcc >>> 11);
    chk("R2 valid high", longint'(dutyValid), 1);
    prevDuty = duty;
    @(negedge clk);
    chk("R2 valid low", longint'(dutyValid), 0);
    chk("R9 duty held", longint'(duty), prevDuty);
  endtask

  initial begin
    for (int i = 0; i < 13; i++) begin mA[i] = 0; mB[i] = 0; mC[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 duty", longint'(duty), 0);
    chk("R1 valid", longint'(dutyValid), 0);
    chk("R1 flag", longint'(codeErr), 0);
    for (int c = 0; c < 13; c++) doSample(c, 1'b0, "R1 zero tables");

    // Signed gains in fraction LSBs; index 6 is zero error.
    for (int i = 0; i < 13; i++) begin
      writeTbl(0, i, (i - 6) * 5000);
      writeTbl(1, i, (i - 6) * -2300);
      writeTbl(2, i, (i - 6) * 700);
    end
    // Sweep codes at all history ages (R3, R4).
    for (int k = 0; k < 13; k++)
      for (int j = 0; j < 3; j++) doSample((k * 5 + j * 7 + 3) % 13, 1'b0, "R3 R4 sweep");

    // Saturation high then low (R5).
    writeTbl(0, 12, 64'h7FFFFF);
    for (int k = 0; k < 4; k++) doSample(12, 1'b0, "R5 rise");
    chk("R5 top", longint'(duty), 8191);
    writeTbl(0, 0, -64'sd8388608);
    for (int k = 0; k < 5; k++) doSample(0, 1'b0, "R5 fall");
    chk("R5 bottom", longint'(duty), 0);

    // Ignored writes (R8): collision, bad select, bad address.
    writeTbl(0, 12, 4000);
    writeTbl(0, 5, -1000);
    doSample(5, 1'b1, "R8 collided write");
    doSample(5, 1'b0, "R8 entry unchanged");
    writeTbl(3, 5, 64'h500000);
    writeTbl(0, 13, 64'h500000);
    writeTbl(1, 15, 64'h500000);
    for (int c = 0; c < 13; c++) doSample(c, 1'b0, "R8 no stray write");

    // Illegal codes (R6, R7).
    chk("R7 flag clear", longint'(codeErr), 0);
    doSample(13, 1'b0, "R6 code13");
    chk("R7 flag set", longint'(codeErr), 1);
    doSample(15, 1'b0, "R6 code15");
    doSample(14, 1'b0, "R6 code14");
    doSample(3, 1'b0, "R6 history clamp");
    doSample(9, 1'b0, "R6 history clamp");
    chk("R7 flag sticky", longint'(codeErr), 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule